// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block sends and receives asynchronous serial characters whose shape is taken from an 8-bit format register. The format register sets the operating mode, the parity mode, the number of transmit stop bits and the low part of a 3-bit character-size code. A small auxiliary register holds the high part of that code and the ninth data bit for each direction. Characters of five to nine data bits are supported. Software reaches the block through a four-entry register bus. The bus selects the data, format, auxiliary and status registers.

A write to the data register launches a frame on the serial output. The frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The receiver oversamples the input line sixteen times per bit, using an external baud tick. It decides each bit by a majority vote and places the character in a holding register, together with parity and framing error flags. A read of the data register releases the held character. The synchronous and SPI master mode encodings are decoded. The block does not implement them: it stays silent while one of them is selected.

Top module: `serial_frame_engine`

## Requirements
- R1: After reset, the format register (select 1) reads 0x06, the auxiliary register (select 2) reads 0x00, the status register (select 3) reads 0x02, and the serial output is high. Select 0 is the data register. Auxiliary bits: bit 2 = size-code high bit, bit 1 = received ninth bit, bit 0 = transmit ninth bit. Status bits: bit 0 = character held, bit 1 = transmitter idle, bit 2 = parity error, bit 3 = framing error.
- R2: The size code {aux bit 2, format bits 2:1} sets the data bit count: 000=5, 001=6, 010=7, 011=8, 111=9. Codes 100, 101 and 110 give 8 bits. A frame is a start bit of 0, then the data bits with the LSB first. The line idles at 1.
- R3: Format bits 5:4 set parity: 00 none, 01 none (reserved), 10 even, 11 odd. With parity on, the transmitter sends a parity bit after the last data bit. With even parity, the data bits and the parity bit together hold an even number of ones.
- R4: Format bit 3 set to 1 makes the transmitter send two stop bits; 0 sends one. The transmitter-idle status bit returns to 1 only after the last stop bit has been sent.
- R5: The receiver samples only one stop bit, whatever format bit 3 holds. A frame that follows straight after a single stop bit is received correctly.
- R6: The receiver computes the parity of the received data bits and compares it with the received parity bit. On a mismatch it sets status bit 2. A stop bit sampled as 0 sets status bit 3. The data is captured in both cases.
- R7: The error flags and the held character stay until the data register is read. Reads of the status and auxiliary registers do not change them. A data register read clears the held flag and both error flags.
- R8: The transmit ninth bit is taken from the auxiliary register when the data register is written. A later auxiliary write does not change the frame already started. The received ninth bit reads back in auxiliary bit 1.
- R9: A data write starts a frame only while format bits 7:6 are 00 (asynchronous). With 01, 10 or 11 the write is ignored and the receiver ignores the line.
- R10: Each bit is the majority of the samples taken at oversample counts 7, 8 and 9. A low pulse that is high again at the middle of the start bit is rejected, and nothing is received.
- R11: If a character completes on the same clock edge as a data register read, the new character is kept and the held flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | Oversample tick, sixteen per bit |
| regSel | input | 2 | Register select: 0 data, 1 format, 2 auxiliary, 3 status |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; releases the character when selecting data |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| rxPin | input | 1 | Serial input |
| txPin | output | 1 | Serial output |

## Verification
The two functions that can land on the same clock edge are the capture of a newly received character and the software read that releases the held one. The bench drives a frame bit by bit from a known negative edge. It counts the two synchronizer stages and the sample counter up to the stop bit decision, and puts the data register read on exactly the capture edge. It then checks two things: the read returned the old character, and the status and data registers show the new character still held.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam int MAX_DATA = 9;
  localparam int CNT_W    = 4;
  localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_FMT  = 2'd1;
  localparam logic [1:0] SEL_AUX  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_SPIM  = 2'b11
  } sfe_mode_e;

  typedef struct packed {
    logic             asyncOn;
    logic [CNT_W-1:0] numBits;
    logic             parEn;
    logic             parOdd;
    logic             twoStop;
  } sfe_fmt_t;

  typedef struct packed {
    sfe_fmt_t              fmt;
    logic                  txStart;
    logic [MAX_DATA-1:0]   txWord;
  } sfe_cmd_t;

  typedef struct packed {
    logic                  txBusy;
    logic                  rxDone;
    logic [MAX_DATA-1:0]   rxWord;
    logic                  parErr;
    logic                  frmErr;
  } sfe_evt_t;

  function automatic logic [CNT_W-1:0] decodeSize(input logic [2:0] code);
    case (code)
      3'b000:  return CNT_W'(5);
      3'b001:  return CNT_W'(6);
      3'b010:  return CNT_W'(7);
      3'b111:  return CNT_W'(9);
      default: return CNT_W'(8);
    endcase
  endfunction

  function automatic logic [MAX_DATA-1:0] sizeMask(input logic [CNT_W-1:0] n);
    logic [MAX_DATA-1:0] m;
    for (int i = 0; i < MAX_DATA; i++) m[i] = (CNT_W'(i) < n);
    return m;
  endfunction

endpackage

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  sfe_evt_t   evt,
  output sfe_cmd_t   cmd
);

  logic [7:0]          fmtReg;
  logic                sizeHi;
  logic                txNinth;
  logic [MAX_DATA-1:0] rxHold;
  logic                rxFull;
  logic                parErrQ;
  logic                frmErrQ;
  sfe_mode_e           mode;
  logic                release_;

  assign mode     = sfe_mode_e'(fmtReg[7:6]);
  assign release_ = rdEn && (regSel == SEL_DATA);

  always_comb begin
    cmd.fmt.asyncOn = (mode == MODE_ASYNC);
    cmd.fmt.parEn   = fmtReg[5];
    cmd.fmt.parOdd  = fmtReg[4];
    cmd.fmt.twoStop = fmtReg[3];
    cmd.fmt.numBits = decodeSize({sizeHi, fmtReg[2:1]});
    cmd.txWord      = {txNinth, wrData};
    cmd.txStart     = wrEn && (regSel == SEL_DATA) && (mode == MODE_ASYNC) && !evt.txBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtReg  <= 8'h06;
      sizeHi  <= 1'b0;
      txNinth <= 1'b0;
    end else if (wrEn) begin
      if (regSel == SEL_FMT) fmtReg <= wrData;
      if (regSel == SEL_AUX) begin
        sizeHi  <= wrData[2];
        txNinth <= wrData[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold  <= '0;
      rxFull  <= 1'b0;
      parErrQ <= 1'b0;
      frmErrQ <= 1'b0;
    end else if (evt.rxDone) begin
      rxHold  <= evt.rxWord;
      rxFull  <= 1'b1;
      parErrQ <= evt.parErr;
      frmErrQ <= evt.frmErr;
    end else if (release_) begin
      rxFull  <= 1'b0;
      parErrQ <= 1'b0;
      frmErrQ <= 1'b0;
    end
  end

  always_comb begin
    case (regSel)
      SEL_DATA: rdData = rxHold[7:0];
      SEL_FMT:  rdData = fmtReg;
      SEL_AUX:  rdData = {5'b0, sizeHi, rxHold[8], txNinth};
      default:  rdData = {4'b0, frmErrQ, parErrQ, !evt.txBusy, rxFull};
    endcase
  end

  // R11: a completed character is never lost to a same-edge release
  p_capture_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    evt.rxDone |=> rxFull);

  // R7: a data read without a new character empties the holding register
  p_release_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (release_ && !evt.rxDone) |=> (!rxFull && !parErrQ && !frmErrQ));

  // R7: nothing but a capture or a release moves the held state
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!evt.rxDone && !release_) |=> ($stable(rxHold) && $stable(parErrQ) && $stable(frmErrQ)));

  // R9: a start is never issued over a running frame
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.txStart |=> evt.txBusy);

endmodule

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     baudTick,
  input  logic     rxPin,
  input  sfe_cmd_t cmd,
  output sfe_evt_t evt,
  output logic     txPin
);

  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  // ---------------- transmitter ----------------
  logic [FRAME_W-1:0]  txShift;
  logic [FRAME_W-1:0]  frameVec;
  logic [CNT_W-1:0]    txLeft;
  logic [CNT_W-1:0]    frameLen;
  logic [CW-1:0]       txTick;
  logic [MAX_DATA:0]   txPadded;
  logic                txPar;
  logic                txBusy;

  always_comb begin
    txPadded = {1'b0, cmd.txWord & sizeMask(cmd.fmt.numBits)};
    txPar    = (^txPadded) ^ cmd.fmt.parOdd;
    frameVec = '1;
    frameVec[0] = 1'b0;
    for (int i = 0; i <= MAX_DATA; i++) begin
      if (CNT_W'(i) < cmd.fmt.numBits)
        frameVec[i+1] = txPadded[i];
      else if ((CNT_W'(i) == cmd.fmt.numBits) && cmd.fmt.parEn)
        frameVec[i+1] = txPar;
    end
    frameLen = CNT_W'(2) + cmd.fmt.numBits + CNT_W'(cmd.fmt.parEn) + CNT_W'(cmd.fmt.twoStop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '1;
      txLeft  <= '0;
      txTick  <= '0;
    end else if (cmd.txStart) begin
      txShift <= frameVec;
      txLeft  <= frameLen;
      txTick  <= '0;
    end else if (txBusy && baudTick) begin
      if (txTick == CW'(OVS-1)) begin
        txShift <= {1'b1, txShift[FRAME_W-1:1]};
        txLeft  <= txLeft - 1'b1;
        txTick  <= '0;
      end else begin
        txTick  <= txTick + 1'b1;
      end
    end
  end

  assign txBusy = (txLeft != '0);
  assign txPin  = txShift[0];

  // ---------------- receiver ----------------
  logic                rxMeta, rxSync;
  logic                rxActive;
  logic [CW-1:0]       rxTick;
  logic [CNT_W-1:0]    rxIdx;
  logic [MAX_DATA:0]   rxBits;
  logic                s0, s1, vote;
  logic [CNT_W-1:0]    lastIdx;
  logic [MAX_DATA-1:0] rxData;
  logic                rxPar;
  logic                rxDoneQ, parErrQ, frmErrQ;
  logic [MAX_DATA-1:0] rxWordQ;

  assign vote    = (s0 & s1) | (s0 & rxSync) | (s1 & rxSync);
  assign lastIdx = CNT_W'(1) + cmd.fmt.numBits + CNT_W'(cmd.fmt.parEn);
  assign rxData  = rxBits[MAX_DATA-1:0] & sizeMask(cmd.fmt.numBits);
  assign rxPar   = rxBits[cmd.fmt.numBits];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxPin;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxTick   <= '0;
      rxIdx    <= '0;
      rxBits   <= '0;
      s0       <= 1'b1;
      s1       <= 1'b1;
      rxDoneQ  <= 1'b0;
      rxWordQ  <= '0;
      parErrQ  <= 1'b0;
      frmErrQ  <= 1'b0;
    end else begin
      rxDoneQ <= 1'b0;
      if (!cmd.fmt.asyncOn) begin
        rxActive <= 1'b0;
      end else if (!rxActive) begin
        if (baudTick && !rxSync) begin
          rxActive <= 1'b1;
          rxTick   <= '0;
          rxIdx    <= '0;
        end
      end else if (baudTick) begin
        rxTick <= rxTick + 1'b1;
        if (rxTick == CW'(MID-1)) s0 <= rxSync;
        if (rxTick == CW'(MID))   s1 <= rxSync;
        if (rxTick == CW'(OVS-1)) begin
          rxTick <= '0;
          rxIdx  <= rxIdx + 1'b1;
        end
        if (rxTick == CW'(MID+1)) begin
          if (rxIdx == '0) begin
            if (vote) rxActive <= 1'b0;
          end else if (rxIdx == lastIdx) begin
            rxActive <= 1'b0;
            rxDoneQ  <= 1'b1;
            rxWordQ  <= rxData;
            parErrQ  <= cmd.fmt.parEn && (rxPar != ((^rxData) ^ cmd.fmt.parOdd));
            frmErrQ  <= !vote;
          end else begin
            rxBits[rxIdx - 1'b1] <= vote;
          end
        end
      end
    end
  end

  always_comb begin
    evt.txBusy = txBusy;
    evt.rxDone = rxDoneQ;
    evt.rxWord = rxWordQ;
    evt.parErr = parErrQ;
    evt.frmErr = frmErrQ;
  end

  // R2: an idle transmitter holds the line high
  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txPin);

  // R2: every frame opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txPin);

  // R4: the last bit before going idle is a stop bit
  p_stop_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> $past(txPin));

  // R9: no character is reported outside asynchronous mode
  p_rx_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.fmt.asyncOn |=> !rxDoneQ);

endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
  import sfe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxPin,
  output logic       txPin
);

  sfe_cmd_t cmd;
  sfe_evt_t evt;

  sfe_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wrData (wrData),
    .rdData (rdData),
    .evt    (evt),
    .cmd    (cmd)
  );

  sfe_datapath #(.OVS(OVS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .rxPin    (rxPin),
    .cmd      (cmd),
    .evt      (evt),
    .txPin    (txPin)
  );

endmodule

// File: tb/serial_frame_engine_test.sv
`timescale 1ns/1ps
module serial_frame_engine_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b1;
  logic [1:0] regSel = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       txPin;
  logic       rxDrv = 1'b1;
  logic       loopOn = 1'b0;
  logic       rxLine;
  int         nVec = 0;
  int         nFail = 0;
  bit         finished = 0;

  always #2 clk = ~clk;
  assign rxLine = loopOn ? txPin : rxDrv;

  serial_frame_engine uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .regSel(regSel),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .rxPin(rxLine), .txPin(txPin)
  );

  // {format[7:0], aux[2:0], data[7:0]}
  localparam logic [18:0] VEC [12] = '{
    {8'h06, 3'b000, 8'hA5}, {8'h00, 3'b000, 8'h3A}, {8'h02, 3'b000, 8'h55},
    {8'h04, 3'b000, 8'h7F}, {8'h26, 3'b000, 8'hC3}, {8'h36, 3'b000, 8'hC3},
    {8'h0E, 3'b000, 8'h81}, {8'h06, 3'b101, 8'h5A}, {8'h36, 3'b100, 8'hFF},
    {8'h16, 3'b000, 8'h0F}, {8'h00, 3'b100, 8'h99}, {8'h22, 3'b000, 8'h2D}
  };

  function automatic int sizeOf(input logic [2:0] c);
    case (c)
      3'b000: return 5;
      3'b001: return 6;
      3'b010: return 7;
      3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [8:0] maskTo(input logic [8:0] w, input int n);
    logic [8:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = w[i];
    return m;
  endfunction

  function automatic logic [12:0] frameOf(input logic [8:0] w, input int n, input int pe,
                                          input bit po, input bit badPar, input bit stopv);
    logic [12:0] f = '1;
    logic [8:0]  m = maskTo(w, n);
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) f[1+i] = m[i];
    if (pe != 0) f[1+n] = (^m) ^ po ^ badPar;
    f[1+n+pe] = stopv;
    return f;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    regSel = s; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    regSel = s; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic sendBits(input logic [12:0] f, input int len);
    for (int k = 0; k < len; k++) begin
      rxDrv = f[k];
      repeat (16) @(negedge clk);
    end
    rxDrv = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    chk("R1 txPin idle", {7'b0, txPin}, 8'h01);
    rd(2'd1, got); chk("R1 format reset", got, 8'h06);
    rd(2'd2, got); chk("R1 aux reset", got, 8'h00);
    rd(2'd3, got); chk("R1 status reset", got, 8'h02);

    // R2 R3 R4 R8: table of loopback frames
    loopOn = 1'b1;
    for (int v = 0; v < 12; v++) begin
      logic [7:0]  f8 = VEC[v][18:11];
      logic [2:0]  ax = VEC[v][10:8];
      logic [7:0]  dt = VEC[v][7:0];
      int          n  = sizeOf({ax[2], f8[2:1]});
      int          pe = int'(f8[5]);
      int          total = 2 + n + pe + int'(f8[3]);
      logic [8:0]  w9 = maskTo({ax[0], dt}, n);
      logic [12:0] fr = frameOf({ax[0], dt}, n, pe, f8[4], 1'b0, 1'b1);
      wr(2'd1, f8);
      wr(2'd2, {5'b0, ax});
      wr(2'd0, dt);
      repeat (7) @(negedge clk);
      for (int k = 0; k < total; k++) begin
        if (k != 0) repeat (16) @(negedge clk);
        chk($sformatf("R2/R3 vec%0d bit%0d", v, k), {7'b0, txPin}, {7'b0, fr[k]});
      end
      rd(2'd3, got); chk($sformatf("R4 vec%0d busy in last stop", v), got & 8'h02, 8'h00);
      repeat (15) @(negedge clk);
      rd(2'd3, got); chk($sformatf("R4 vec%0d idle after stop", v), got, 8'h03);
      rd(2'd2, got); chk($sformatf("R8 vec%0d aux", v), got, {5'b0, ax[2], w9[8], ax[0]});
      rd(2'd0, got); chk($sformatf("R2 vec%0d rx data", v), got, w9[7:0]);
      rd(2'd3, got); chk($sformatf("R7 vec%0d released", v), got, 8'h02);
    end

    // R8: aux rewrite during a 9-bit frame does not alter it
    wr(2'd1, 8'h06); wr(2'd2, 8'h05); wr(2'd0, 8'h00); wr(2'd2, 8'h04);
    repeat (200) @(negedge clk);
    rd(2'd2, got); chk("R8 ninth bit latched at data write", got, 8'h06);
    rd(2'd0, got); chk("R8 low bits", got, 8'h00);
    wr(2'd2, 8'h00);
    loopOn = 1'b0;

    // R6 R7: parity error, flags survive status and aux reads
    wr(2'd1, 8'h26);
    sendBits(frameOf(9'h035, 8, 1, 1'b0, 1'b1, 1'b1), 11);
    repeat (10) @(negedge clk);
    rd(2'd3, got); chk("R6 parity error flag", got, 8'h07);
    rd(2'd2, got); rd(2'd3, got); chk("R7 flags after aux read", got, 8'h07);
    rd(2'd0, got); chk("R6 data with parity error", got, 8'h35);
    rd(2'd3, got); chk("R7 flags cleared by data read", got, 8'h02);

    // R6: framing error
    wr(2'd1, 8'h06);
    sendBits(frameOf(9'h06C, 8, 0, 1'b0, 1'b0, 1'b0), 10);
    repeat (40) @(negedge clk);
    rd(2'd3, got); chk("R6 frame error flag", got, 8'h0B);
    rd(2'd0, got); chk("R6 data with frame error", got, 8'h6C);
    rd(2'd3, got); chk("R6 cleared", got, 8'h02);

    // R10: short low glitch is a false start
    rxDrv = 1'b0; repeat (5) @(negedge clk); rxDrv = 1'b1;
    repeat (60) @(negedge clk);
    rd(2'd3, got); chk("R10 false start rejected", got, 8'h02);

    // R5: two-stop setting, back-to-back single-stop frames
    wr(2'd1, 8'h0E);
    sendBits(frameOf(9'h0A1, 8, 0, 1'b0, 1'b0, 1'b1), 10);
    sendBits(frameOf(9'h05E, 8, 0, 1'b0, 1'b0, 1'b1), 10);
    repeat (10) @(negedge clk);
    rd(2'd3, got); chk("R5 single stop accepted", got, 8'h03);
    rd(2'd0, got); chk("R5 second frame data", got, 8'h5E);

    // R11: capture and release on the same edge
    wr(2'd1, 8'h06);
    sendBits(frameOf(9'h03C, 8, 0, 1'b0, 1'b0, 1'b1), 10);
    repeat (10) @(negedge clk);
    fork
      sendBits(frameOf(9'h0C5, 8, 0, 1'b0, 1'b0, 1'b1), 10);
      begin
        repeat (157) @(negedge clk);
        rd(2'd0, got);
        chk("R11 read returns old character", got, 8'h3C);
      end
    join
    rd(2'd3, got); chk("R11 new character held", got, 8'h03);
    rd(2'd0, got); chk("R11 new character data", got, 8'hC5);

    // R9: non-asynchronous modes ignore writes and the line
    for (int m = 1; m < 4; m++) begin
      wr(2'd1, {2'(m), 6'b000110});
      wr(2'd0, 8'h55);
      repeat (8) @(negedge clk);
      chk($sformatf("R9 mode%0d tx silent", m), {7'b0, txPin}, 8'h01);
      sendBits(frameOf(9'h055, 8, 0, 1'b0, 1'b0, 1'b1), 10);
      repeat (10) @(negedge clk);
      rd(2'd3, got); chk($sformatf("R9 mode%0d rx ignored", m), got, 8'h02);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule